// File: doc/BRIEF.md
# Power-Gating Sequencer Controller

This block is an always-on controller that steps two switchable supply domains between a fixed set of four legal power states. One domain runs from the low-voltage rail and keeps part of its state through retention cells. The other runs from the high-voltage rail and has no retention. The controller takes a requested state code. For each domain it drives three controls: a switch-off control (high removes power), an active-low isolation control, and, for the low-voltage domain only, a level-sensitive retention line (high saves, low restores).

Power-down of a domain follows a fixed order. Isolation is asserted first, then retention save, then a wait of `DOWN_WAIT` cycles, and only then is the switch opened. Power-up runs the other way round. The switch closes, the controller waits `UP_SETTLE` cycles, then releases retention so the saved state is restored, and finally releases isolation. Only one domain is sequenced at a time. A request that arrives during a sequence is held, and the newest request is acted on once the controller is stable again.

The block also contains a behavioural model of the parent-side output clamps. While a domain is isolated, each of its outputs is forced to a fixed value. While it is not isolated, each output passes the domain's own value through.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset both switch-off controls are 1, both isolation controls are 0 (asserted), retention save is 1, busy is 0 and the state code is 2'b00.
- R2: State code encoding: bit 1 set means the low-voltage domain is powered and bit 0 set means the high-voltage domain is powered. So 00 is both off, 01 is high-voltage only, 10 is low-voltage only and 11 is both on. Whenever busy is 0 the code matches the switch controls.
- R3: A domain power-down that starts in sample s drops isolation in s. For the low-voltage domain it raises retention in s+1. It raises the switch-off control in s+1+DOWN_WAIT, and the state code is updated in that same cycle.
- R4: A domain power-up that starts in sample s drops the switch-off control in s. For the low-voltage domain it drops retention in s+UP_SETTLE. It raises isolation in s+UP_SETTLE+1, and the state code is updated in that same cycle.
- R5: Only one domain changes its controls in any cycle, and the domains are handled in a fixed order:
  - power-downs come before power-ups;
  - within the same direction, the low-voltage domain goes first;
  - the next domain starts in the cycle after the previous step ends.
- R6: A request made while busy is held and carried out after the current target is reached. If several requests arrive while busy, the newest one wins.
- R7: A request for the state already held causes no control change, and busy stays 0.
- R8: Busy rises 2 cycles after the request cycle, and the first control change comes 3 cycles after it. Busy falls in the cycle of the final control change.
- R9: While low-voltage isolation is 0, low-voltage output 0 is forced to 1 and output 1 is forced to 0. Otherwise both outputs pass the domain's values through.
- R10: While high-voltage isolation is 0, the high-voltage output is forced to 1. Otherwise it passes the domain's value through.
- R11: The high-voltage domain has no retention; its internal retention control stays 0.
- R12: Whenever a domain's switch-off control is 1, its isolation is 0. For the low-voltage domain, retention is also 1 at those times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_state | input | 2 | Requested state code (R2 encoding) |
| lo_core_out | input | 2 | Raw outputs of the low-voltage gated domain |
| hi_core_out | input | 1 | Raw output of the high-voltage gated domain |
| lo_sw_off | output | 1 | Low-voltage switch control, 1 removes power |
| lo_iso_n | output | 1 | Low-voltage isolation, active low |
| lo_ret_save | output | 1 | Retention line, 1 saves, 0 restores |
| hi_sw_off | output | 1 | High-voltage switch control, 1 removes power |
| hi_iso_n | output | 1 | High-voltage isolation, active low |
| lo_edge_out | output | 2 | Clamped low-voltage domain outputs |
| hi_edge_out | output | 1 | Clamped high-voltage domain output |
| busy | output | 1 | Sequence in progress |
| state_code | output | 2 | Current stable state code |

## Verification
Counting from the request cycle as sample 0, busy is due in sample 2 and the first control edge in sample 3. Each later edge falls at an offset set by DOWN_WAIT or UP_SETTLE, and the step for the next domain begins one sample after the previous step's last edge. The bench works out the expected sample of every control edge arithmetically for all sixteen start-to-target pairs. After each clock edge it samples on the falling clock edge, records the first sample in which each control changed, and compares that sample with the expected one. The clamp outputs are combinational from the isolation controls, so they are compared in the same sample as the isolation value that was observed.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_DARK    = 2'b00,
        PS_HI_ONLY = 2'b01,
        PS_LO_ONLY = 2'b10,
        PS_FULL    = 2'b11
    } pwr_code_t;

    localparam int NUM_DOM = 2;
    localparam int DOM_LO  = 0;
    localparam int DOM_HI  = 1;

    typedef struct packed {
        logic dom;   // 0 low-voltage, 1 high-voltage
        logic up;    // 1 power-up, 0 power-down
    } step_t;

    function automatic int code_bit(input logic dom);
        return (dom == 1'b0) ? 1 : 0;
    endfunction

    function automatic step_t pick_step(input pwr_code_t cur, input pwr_code_t tgt);
        step_t s;
        logic  diff_lo, diff_hi;
        diff_lo = cur[1] ^ tgt[1];
        diff_hi = cur[0] ^ tgt[0];
        if (diff_lo && cur[1]) begin
            s.dom = 1'b0; s.up = 1'b0;
        end else if (diff_hi && cur[0]) begin
            s.dom = 1'b1; s.up = 1'b0;
        end else if (diff_lo) begin
            s.dom = 1'b0; s.up = 1'b1;
        end else begin
            s.dom = 1'b1; s.up = 1'b1;
        end
        return s;
    endfunction

    function automatic pwr_code_t apply_step(input pwr_code_t cur, input step_t s);
        logic [1:0] v;
        v = cur;
        if (s.dom == 1'b0) v[1] = s.up;
        else               v[0] = s.up;
        return pwr_code_t'(v);
    endfunction

endpackage

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
    parameter bit HAS_RET   = 1'b1,
    parameter int DOWN_WAIT = 4,
    parameter int UP_SETTLE = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic go_up,
    output logic sw_off,
    output logic iso_n,
    output logic ret,
    output logic done
);
    localparam int MAXW   = (DOWN_WAIT > UP_SETTLE) ? DOWN_WAIT : UP_SETTLE;
    localparam int CNT_W  = $clog2(MAXW + 1);
    localparam logic [CNT_W-1:0] DN_LAST = CNT_W'(DOWN_WAIT - 1);
    localparam logic [CNT_W-1:0] UP_LAST = CNT_W'(UP_SETTLE - 1);
    localparam logic RET_ON = HAS_RET;

    typedef enum logic [2:0] {
        S_OFF, S_ON, S_DN_RET, S_DN_WAIT, S_UP_WAIT, S_UP_ISO
    } seq_st_t;

    seq_st_t          st;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        done = ((st == S_DN_WAIT) && (cnt == DN_LAST)) || (st == S_UP_ISO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_OFF;
            cnt    <= '0;
            sw_off <= 1'b1;
            iso_n  <= 1'b0;
            ret    <= RET_ON;
        end else begin
            case (st)
                S_ON: begin
                    if (start && !go_up) begin
                        iso_n <= 1'b0;
                        st    <= S_DN_RET;
                    end
                end
                S_DN_RET: begin
                    ret <= RET_ON;
                    cnt <= '0;
                    st  <= S_DN_WAIT;
                end
                S_DN_WAIT: begin
                    if (cnt == DN_LAST) begin
                        sw_off <= 1'b1;
                        st     <= S_OFF;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_OFF: begin
                    if (start && go_up) begin
                        sw_off <= 1'b0;
                        cnt    <= '0;
                        st     <= S_UP_WAIT;
                    end
                end
                S_UP_WAIT: begin
                    if (cnt == UP_LAST) begin
                        ret <= 1'b0;
                        st  <= S_UP_ISO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_UP_ISO: begin
                    iso_n <= 1'b1;
                    st    <= S_ON;
                end
                default: st <= S_OFF;
            endcase
        end
    end
endmodule

// File: rtl/pwr_seq_plan.sv
module pwr_seq_plan
    import pwr_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_state,
    input  logic [NUM_DOM-1:0] seq_done,
    output logic [NUM_DOM-1:0] seq_start,
    output logic               seq_up,
    output logic               busy,
    output logic [1:0]         state_code
);
    typedef enum logic [1:0] { P_IDLE, P_LAUNCH, P_RUN } phase_t;

    phase_t    phase;
    logic      pend_vld;
    pwr_code_t pend_code;
    pwr_code_t tgt;
    pwr_code_t cur;
    step_t     step;
    step_t     nxt;
    pwr_code_t after;
    logic      done_hit;
    logic      consume;

    always_comb begin
        nxt      = pick_step(cur, tgt);
        after    = apply_step(cur, step);
        done_hit = seq_done[step.dom];
        consume  = (phase == P_IDLE) && pend_vld;
        seq_up   = nxt.up;
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_start
        assign seq_start[d] = (phase == P_LAUNCH) && (nxt.dom == d[0]);
    end

    assign state_code = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= P_IDLE;
            pend_vld  <= 1'b0;
            pend_code <= PS_DARK;
            tgt       <= PS_DARK;
            cur       <= PS_DARK;
            step      <= '0;
            busy      <= 1'b0;
        end else begin
            if (req_valid) begin
                pend_vld  <= 1'b1;
                pend_code <= pwr_code_t'(req_state);
            end else if (consume) begin
                pend_vld <= 1'b0;
            end
            case (phase)
                P_IDLE: begin
                    if (pend_vld) begin
                        tgt <= pend_code;
                        if (pend_code != cur) begin
                            phase <= P_LAUNCH;
                            busy  <= 1'b1;
                        end
                    end
                end
                P_LAUNCH: begin
                    step  <= nxt;
                    phase <= P_RUN;
                end
                P_RUN: begin
                    if (done_hit) begin
                        cur <= after;
                        if (after == tgt) begin
                            phase <= P_IDLE;
                            busy  <= 1'b0;
                        end else begin
                            phase <= P_LAUNCH;
                        end
                    end
                end
                default: phase <= P_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwr_iso_clamp.sv
module pwr_iso_clamp #(
    parameter int           W     = 2,
    parameter logic [W-1:0] CLAMP = '0
) (
    input  logic         iso_n,
    input  logic [W-1:0] core_in,
    output logic [W-1:0] edge_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign edge_out[i] = iso_n ? core_in[i] : CLAMP[i];
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int DOWN_WAIT = 4,
    parameter int UP_SETTLE = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_state,
    input  logic [1:0] lo_core_out,
    input  logic       hi_core_out,
    output logic       lo_sw_off,
    output logic       lo_iso_n,
    output logic       lo_ret_save,
    output logic       hi_sw_off,
    output logic       hi_iso_n,
    output logic [1:0] lo_edge_out,
    output logic       hi_edge_out,
    output logic       busy,
    output logic [1:0] state_code
);
    logic [NUM_DOM-1:0] seq_start;
    logic [NUM_DOM-1:0] seq_done;
    logic               seq_up;
    logic [NUM_DOM-1:0] sw_off_v;
    logic [NUM_DOM-1:0] iso_n_v;
    logic [NUM_DOM-1:0] ret_v;

    pwr_seq_plan plan_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_state  (req_state),
        .seq_done   (seq_done),
        .seq_start  (seq_start),
        .seq_up     (seq_up),
        .busy       (busy),
        .state_code (state_code)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pwr_dom_seq #(
            .HAS_RET   (d == DOM_LO),
            .DOWN_WAIT (DOWN_WAIT),
            .UP_SETTLE (UP_SETTLE)
        ) seq_i (
            .clk    (clk),
            .rst    (rst),
            .start  (seq_start[d]),
            .go_up  (seq_up),
            .sw_off (sw_off_v[d]),
            .iso_n  (iso_n_v[d]),
            .ret    (ret_v[d]),
            .done   (seq_done[d])
        );
    end

    assign lo_sw_off   = sw_off_v[DOM_LO];
    assign lo_iso_n    = iso_n_v[DOM_LO];
    assign lo_ret_save = ret_v[DOM_LO];
    assign hi_sw_off   = sw_off_v[DOM_HI];
    assign hi_iso_n    = iso_n_v[DOM_HI];

    pwr_iso_clamp #(.W(2), .CLAMP(2'b01)) lo_clamp_i (
        .iso_n    (lo_iso_n),
        .core_in  (lo_core_out),
        .edge_out (lo_edge_out)
    );

    pwr_iso_clamp #(.W(1), .CLAMP(1'b1)) hi_clamp_i (
        .iso_n    (hi_iso_n),
        .core_in  (hi_core_out),
        .edge_out (hi_edge_out)
    );
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       lo_sw_off,
    input logic       lo_iso_n,
    input logic       lo_ret_save,
    input logic       hi_sw_off,
    input logic       hi_iso_n,
    input logic [1:0] lo_edge_out,
    input logic       hi_edge_out,
    input logic       busy,
    input logic [1:0] state_code,
    input logic [1:0] ret_v
);
    assert_lo_off_safe_R12: assert property (@(posedge clk) disable iff (rst)
        lo_sw_off |-> (!lo_iso_n && lo_ret_save));

    assert_hi_off_safe_R12: assert property (@(posedge clk) disable iff (rst)
        hi_sw_off |-> !hi_iso_n);

    assert_hi_no_ret_R11: assert property (@(posedge clk) disable iff (rst)
        ret_v[1] == 1'b0);

    assert_lo_clamp_R9: assert property (@(posedge clk) disable iff (rst)
        !lo_iso_n |-> (lo_edge_out == 2'b01));

    assert_hi_clamp_R10: assert property (@(posedge clk) disable iff (rst)
        !hi_iso_n |-> hi_edge_out);

    assert_one_dom_R5: assert property (@(posedge clk) disable iff (rst)
        !(!$stable({lo_sw_off, lo_iso_n, lo_ret_save}) && !$stable({hi_sw_off, hi_iso_n})));

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (state_code == {~lo_sw_off, ~hi_sw_off}));

    assert_iso_last_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_iso_n) |-> (!lo_sw_off && !lo_ret_save));

    assert_iso_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_sw_off) |-> $past(!lo_iso_n && lo_ret_save));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .lo_sw_off   (lo_sw_off),
    .lo_iso_n    (lo_iso_n),
    .lo_ret_save (lo_ret_save),
    .hi_sw_off   (hi_sw_off),
    .hi_iso_n    (hi_iso_n),
    .lo_edge_out (lo_edge_out),
    .hi_edge_out (hi_edge_out),
    .busy        (busy),
    .state_code  (state_code),
    .ret_v       (ret_v)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
    localparam int DW = 4;
    localparam int US = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_state = 2'b00;
    logic [1:0] lo_core_out = 2'b00;
    logic       hi_core_out = 1'b0;
    logic       lo_sw_off, lo_iso_n, lo_ret_save, hi_sw_off, hi_iso_n;
    logic [1:0] lo_edge_out;
    logic       hi_edge_out;
    logic       busy;
    logic [1:0] state_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int cyc = 0;
    logic [1:0] model_code = 2'b00;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.DOWN_WAIT(DW), .UP_SETTLE(US)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_state(req_state),
        .lo_core_out(lo_core_out), .hi_core_out(hi_core_out),
        .lo_sw_off(lo_sw_off), .lo_iso_n(lo_iso_n), .lo_ret_save(lo_ret_save),
        .hi_sw_off(hi_sw_off), .hi_iso_n(hi_iso_n),
        .lo_edge_out(lo_edge_out), .hi_edge_out(hi_edge_out),
        .busy(busy), .state_code(state_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // clamp check against the isolation value observed at the ports
    task automatic chk_clamp();
        logic [1:0] lo_exp;
        logic       hi_exp;
        lo_exp = lo_iso_n ? lo_core_out : 2'b01;
        hi_exp = hi_iso_n ? hi_core_out : 1'b1;
        chk("R9 low clamp", int'(lo_edge_out), int'(lo_exp));
        chk("R10 high clamp", int'(hi_edge_out), int'(hi_exp));
    endtask

    task automatic step_cycle();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        lo_core_out = 2'(cyc);
        hi_core_out = cyc[2];
        #0;
    endtask

    // Drives one request and checks the sample index of every control edge.
    task automatic run_to(input logic [1:0] tgt);
        int e_lsw, e_liso, e_lret, e_hsw, e_hiso, e_end;
        int f_lsw, f_liso, f_lret, f_hsw, f_hiso, f_brise, f_bfall;
        int s;
        logic [1:0] c;
        logic p_lsw, p_liso, p_lret, p_hsw, p_hiso, p_busy;
        e_lsw = -1; e_liso = -1; e_lret = -1; e_hsw = -1; e_hiso = -1; e_end = 0;
        s = 3;
        c = model_code;
        while (c != tgt) begin
            logic lo_dn, hi_dn, dom, up;
            lo_dn = (c[1] ^ tgt[1]) & c[1];
            hi_dn = (c[0] ^ tgt[0]) & c[0];
            if (lo_dn) begin dom = 0; up = 0; end
            else if (hi_dn) begin dom = 1; up = 0; end
            else if (c[1] ^ tgt[1]) begin dom = 0; up = 1; end
            else begin dom = 1; up = 1; end
            if (!up) begin
                if (dom == 0) begin e_liso = s; e_lret = s + 1; e_lsw = s + 1 + DW; end
                else begin e_hiso = s; e_hsw = s + 1 + DW; end
                e_end = s + 1 + DW;
                s = s + DW + 2;
            end else begin
                if (dom == 0) begin e_lsw = s; e_lret = s + US; e_liso = s + US + 1; end
                else begin e_hsw = s; e_hiso = s + US + 1; end
                e_end = s + US + 1;
                s = s + US + 2;
            end
            if (dom == 0) c[1] = up; else c[0] = up;
        end
        f_lsw = -1; f_liso = -1; f_lret = -1; f_hsw = -1; f_hiso = -1;
        f_brise = -1; f_bfall = -1;
        p_lsw = lo_sw_off; p_liso = lo_iso_n; p_lret = lo_ret_save;
        p_hsw = hi_sw_off; p_hiso = hi_iso_n; p_busy = busy;
        req_valid = 1'b1;
        req_state = tgt;
        for (int k = 1; k <= e_end + 4; k++) begin
            step_cycle();
            req_valid = 1'b0;
            if (lo_sw_off != p_lsw && f_lsw < 0) f_lsw = k;
            if (lo_iso_n != p_liso && f_liso < 0) f_liso = k;
            if (lo_ret_save != p_lret && f_lret < 0) f_lret = k;
            if (hi_sw_off != p_hsw && f_hsw < 0) f_hsw = k;
            if (hi_iso_n != p_hiso && f_hiso < 0) f_hiso = k;
            if (busy && !p_busy && f_brise < 0) f_brise = k;
            if (!busy && p_busy && f_bfall < 0) f_bfall = k;
            p_lsw = lo_sw_off; p_liso = lo_iso_n; p_lret = lo_ret_save;
            p_hsw = hi_sw_off; p_hiso = hi_iso_n; p_busy = busy;
            chk_clamp();
        end
        chk("R3/R4 low switch edge sample", f_lsw, e_lsw);
        chk("R3/R4 low isolation edge sample", f_liso, e_liso);
        chk("R3/R4 low retention edge sample", f_lret, e_lret);
        chk("R3/R4/R5 high switch edge sample", f_hsw, e_hsw);
        chk("R3/R4/R5 high isolation edge sample", f_hiso, e_hiso);
        chk("R8/R7 busy rise sample", f_brise, (e_end > 0) ? 2 : -1);
        chk("R8/R7 busy fall sample", f_bfall, (e_end > 0) ? e_end : -1);
        chk("R2 state code", int'(state_code), int'(tgt));
        chk("R2 low switch matches code", int'(lo_sw_off), int'(!tgt[1]));
        chk("R2 high switch matches code", int'(hi_sw_off), int'(!tgt[0]));
        model_code = tgt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0;
        // R1 reset state
        chk("R1 low switch off", int'(lo_sw_off), 1);
        chk("R1 high switch off", int'(hi_sw_off), 1);
        chk("R1 low isolation", int'(lo_iso_n), 0);
        chk("R1 high isolation", int'(hi_iso_n), 0);
        chk("R1 retention save", int'(lo_ret_save), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 state code", int'(state_code), 0);
        chk_clamp();

        // sweep over all start/target pairs; includes same-state requests (R7)
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                run_to(2'(f));
                run_to(2'(t));
            end
        end

        // R6: requests while busy are held, newest wins
        run_to(2'b00);
        req_valid = 1'b1; req_state = 2'b11;
        step_cycle();
        req_valid = 1'b0;
        repeat (3) step_cycle();
        chk("R6 busy during first request", int'(busy), 1);
        req_valid = 1'b1; req_state = 2'b01;
        step_cycle();
        req_valid = 1'b1; req_state = 2'b10;
        step_cycle();
        req_valid = 1'b0;
        for (int k = 0; k < 200; k++) begin
            step_cycle();
            chk_clamp();
        end
        chk("R6 final code is newest request", int'(state_code), 2);
        chk("R6 idle after held request", int'(busy), 0);
        chk("R6 low domain powered", int'(lo_sw_off), 0);
        chk("R6 high domain off", int'(hi_sw_off), 1);
        chk("R6 low isolation released", int'(lo_iso_n), 1);
        chk("R6 high isolation held", int'(hi_iso_n), 0);
        chk("R11/R6 retention restored", int'(lo_ret_save), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule